// File: doc/BRIEF.md
# Atomic Conditional Compare-Add Unit

This execution block carries out one atomic read-modify-write on memory. A request names a memory word, a compare operand, an addend, a 4-bit condition selector, an operand-size bit and the two-bit addressing-mode field of the operation. The unit first checks whether the request is legal. It then reads the word under a lock and subtracts the compare operand from the loaded value to form arithmetic flags. It tests the selected condition on those flags. It always closes the lock with a write: the write stores the loaded value plus the addend when the condition holds, and stores the loaded value unchanged when it does not.

The result returns the original memory value, which is meant for the compare-operand register. It also returns the six flags, whether the condition held, and an invalid-opcode indication. The memory side is a single request channel with a valid/ready handshake, plus one response pulse that carries read data or acknowledges a write. A new request is taken only after the unlocking write has been acknowledged and the result has been presented.

Top module: `atomic_cmpadd_unit`

## Requirements
- R1: The selector picks the condition on the compare flags: 0 OF=1, 1 OF=0, 2 CF=1, 3 CF=0, 4 ZF=1, 5 ZF=0, 6 CF=1 or ZF=1, 7 CF=0 and ZF=0, 8 SF=1, 9 SF=0, A PF=1, B PF=0, C SF!=OF, D SF=OF, E ZF=1 or SF!=OF, F ZF=0 and SF=OF. The result is reported on `rspCondMet`.
- R2: `rspFlags` holds the flags of (loaded value minus compare operand), packed as bit0 CF (unsigned borrow), bit1 PF, bit2 AF, bit3 ZF, bit4 SF, bit5 OF (signed overflow). The flags are produced whether or not the condition holds.
- R3: The condition is decided from the compare flags only; how the addition would set flags, such as a signed overflow of loaded value plus addend, has no effect on the decision.
- R4: The read is issued with `memLock`=1 and `memWrite`=0. Every legal request ends with exactly one write with `memLock`=0 to the same address. That write carries loaded+addend when the condition holds and the loaded value otherwise.
- R5: `rspOld` always returns the original memory value, whether or not the add took place.
- R6: `reqWide`=0 selects 32-bit operation. Only bits 31:0 are used for the compare, the flags, the sum and the write, and `memWide`=0 marks a write of bits 31:0 only. `rspOld` and `memWdata` are zero-extended above bit 31. `reqWide`=1 selects full 64-bit operation.
- R7: A request with `reqMode`=3 (register form) returns `rspIllegal`=1, `rspOld`=0, `rspFlags`=0 and `rspCondMet`=0, and makes no memory request.
- R8: A request with `reqLockPfx`=1 is rejected the same way as in R7, with no memory request.
- R9: PF is 1 when the low 8 bits of the difference hold an even number of ones. AF is the borrow out of bit 3, that is loaded[3:0] < compare[3:0].
- R10: `reqReady` stays 0 from the accepted request until the cycle after the one-cycle `rspValid` pulse. `memReqValid` holds its request, with the same address and direction, until `memReqReady` is seen.
- R11: After reset `reqReady`=1, `rspValid`=0 and `memReqValid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Unit idle and able to accept |
| reqCond | input | 4 | Condition selector |
| reqWide | input | 1 | 1 = 64-bit, 0 = 32-bit operands |
| reqMode | input | 2 | Addressing-mode field; 3 is illegal |
| reqLockPfx | input | 1 | Explicit lock prefix present (illegal) |
| reqAddr | input | ADDR_W | Memory address |
| reqCmp | input | DATA_W | Compare operand |
| reqAddend | input | DATA_W | Addend |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory accepts request |
| memWrite | output | 1 | 1 = write, 0 = read |
| memLock | output | 1 | Locked read marker |
| memWide | output | 1 | Access size, 1 = 64-bit |
| memAddr | output | ADDR_W | Memory address |
| memWdata | output | DATA_W | Write data |
| memRspValid | input | 1 | Read data valid or write acknowledge |
| memRspData | input | DATA_W | Read data |
| rspValid | output | 1 | Result pulse |
| rspOld | output | DATA_W | Original memory value |
| rspFlags | output | 6 | {OF,SF,ZF,AF,PF,CF} |
| rspCondMet | output | 1 | Selected condition held |
| rspIllegal | output | 1 | Invalid-opcode indication |

## Verification
The bench aims at conditions where the compare and the addition disagree. One example is a loaded value at the signed maximum with an addend of one: a unit that tested the add flags would write when it should not. It drives 32-bit requests at words whose upper half is nonzero, so a unit that leaked bits 63:32 into the compare, the sum or `rspOld` produces wrong flags or a wrong value. Illegal mode and explicit-lock requests are counted against memory handshakes, which catches a unit that touches memory before rejecting. Every failing condition is checked for an unlocking write of the unchanged value; a unit that skipped that write would leave the lock held, and the bench reports the missing write.

// File: rtl/acx_pkg.sv
package acx_pkg;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } acx_flags_t;

  typedef struct packed {
    logic capReq;
    logic capLoad;
  } acx_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT,
    ST_DONE
  } acx_state_t;

  localparam logic [1:0] MODE_REGISTER = 2'b11;

endpackage

// File: rtl/acx_flag_eval.sv
module acx_flag_eval #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]  loadVal,
  input  logic [DATA_W-1:0]  cmpVal,
  input  logic               wide,
  input  logic [3:0]         sel,
  output acx_pkg::acx_flags_t flags,
  output logic               condMet
);
  import acx_pkg::*;

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] laneMask;
  logic [DATA_W-1:0] aVal, bVal, diffVal;
  logic [DATA_W:0]   diffExt;
  int                topIdx;
  logic              baseCond;

  always_comb begin
    laneMask = wide ? {DATA_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    aVal     = loadVal & laneMask;
    bVal     = cmpVal & laneMask;
    diffExt  = {1'b0, aVal} - {1'b0, bVal};
    diffVal  = diffExt[DATA_W-1:0] & laneMask;
    topIdx   = wide ? DATA_W - 1 : HALF_W - 1;

    flags.cf = wide ? diffExt[DATA_W] : diffExt[HALF_W];
    flags.zf = (diffVal == '0);
    flags.sf = diffVal[topIdx];
    flags.of = (aVal[topIdx] != bVal[topIdx]) && (diffVal[topIdx] != aVal[topIdx]);
    flags.af = (aVal[3:0] < bVal[3:0]);
    flags.pf = ~(^diffVal[7:0]);
  end

  // Even selectors test a base condition, odd selectors its inverse.
  always_comb begin
    unique case (sel[3:1])
      3'd0: baseCond = flags.of;
      3'd1: baseCond = flags.cf;
      3'd2: baseCond = flags.zf;
      3'd3: baseCond = flags.cf | flags.zf;
      3'd4: baseCond = flags.sf;
      3'd5: baseCond = flags.pf;
      3'd6: baseCond = flags.sf ^ flags.of;
      default: baseCond = flags.zf | (flags.sf ^ flags.of);
    endcase
    condMet = baseCond ^ sel[0];
  end

endmodule

// File: rtl/acx_datapath.sv
module acx_datapath #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  acx_pkg::acx_strobe_t strobe,
  input  logic [3:0]           reqCond,
  input  logic                 reqWide,
  input  logic [1:0]           reqMode,
  input  logic                 reqLockPfx,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqCmp,
  input  logic [DATA_W-1:0]    reqAddend,
  input  logic [DATA_W-1:0]    memRspData,
  output logic                 reqIllegal,
  output logic                 memWide,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [DATA_W-1:0]    memWdata,
  output logic [DATA_W-1:0]    rspOld,
  output logic [5:0]           rspFlags,
  output logic                 rspCondMet,
  output logic                 rspIllegal
);
  import acx_pkg::*;

  localparam int HALF_W = DATA_W / 2;

  logic [3:0]        condR;
  logic              wideR;
  logic              illegalR;
  logic [ADDR_W-1:0] addrR;
  logic [DATA_W-1:0] cmpR, addR, loadR;
  logic [DATA_W-1:0] laneMask, sumVal;
  acx_flags_t        cmpFlags;
  logic              condNow;

  assign reqIllegal = (reqMode == MODE_REGISTER) || reqLockPfx;
  assign laneMask   = wideR ? {DATA_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      condR    <= '0;
      wideR    <= 1'b0;
      illegalR <= 1'b0;
      addrR    <= '0;
      cmpR     <= '0;
      addR     <= '0;
      loadR    <= '0;
    end else begin
      if (strobe.capReq) begin
        condR    <= reqCond;
        wideR    <= reqWide;
        illegalR <= reqIllegal;
        addrR    <= reqAddr;
        cmpR     <= reqCmp;
        addR     <= reqAddend;
        loadR    <= '0;
      end
      if (strobe.capLoad) begin
        loadR <= memRspData & laneMask;
      end
    end
  end

  acx_flag_eval #(.DATA_W(DATA_W)) u_flagEval (
    .loadVal (loadR),
    .cmpVal  (cmpR),
    .wide    (wideR),
    .sel     (condR),
    .flags   (cmpFlags),
    .condMet (condNow)
  );

  assign sumVal     = (loadR + addR) & laneMask;
  assign memWdata   = condNow ? sumVal : loadR;
  assign memAddr    = addrR;
  assign memWide    = wideR;
  assign rspOld     = illegalR ? '0 : loadR;
  assign rspFlags   = illegalR ? 6'b0 : cmpFlags;
  assign rspCondMet = illegalR ? 1'b0 : condNow;
  assign rspIllegal = illegalR;

  // R2: an equal compare never reports a borrow, a negative sign or an overflow.
  a_r2_zero_excludes: assert property (@(posedge clk) disable iff (!rstN)
    (!illegalR && cmpFlags.zf) |-> (!cmpFlags.cf && !cmpFlags.sf && !cmpFlags.of));

  // R6: a narrow operation never drives bits above the low half of the write data.
  a_r6_narrow_write: assert property (@(posedge clk) disable iff (!rstN)
    (!wideR) |-> (memWdata[DATA_W-1:HALF_W] == '0));

  // R4: a failing condition writes back exactly what was loaded.
  a_r4_fail_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (!condNow) |-> (memWdata == loadR));

endmodule

// File: rtl/acx_control.sv
module acx_control (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqIllegal,
  input  logic                 memReqReady,
  input  logic                 memRspValid,
  output logic                 reqReady,
  output logic                 memReqValid,
  output logic                 memWrite,
  output logic                 memLock,
  output logic                 rspValid,
  output acx_pkg::acx_strobe_t strobe
);
  import acx_pkg::*;

  acx_state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.capReq = 1'b1;
          stateNext     = reqIllegal ? ST_DONE : ST_RD_REQ;
        end
      end
      ST_RD_REQ:  if (memReqReady) stateNext = ST_RD_WAIT;
      ST_RD_WAIT: begin
        if (memRspValid) begin
          strobe.capLoad = 1'b1;
          stateNext      = ST_WR_REQ;
        end
      end
      ST_WR_REQ:  if (memReqReady) stateNext = ST_WR_WAIT;
      ST_WR_WAIT: if (memRspValid) stateNext = ST_DONE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_RD_REQ) || (state == ST_WR_REQ);
  assign memWrite    = (state == ST_WR_REQ);
  assign memLock     = (state == ST_RD_REQ);
  assign rspValid    = (state == ST_DONE);

  // R7 and R8: a rejected request goes straight to the result with no memory request.
  a_r7_illegal_nomem: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqIllegal) |=> (!memReqValid && rspValid));

  // R10: an unaccepted memory request is held.
  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memWrite)));

  // R10: the result pulse lasts one cycle and is followed by readiness.
  a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && reqReady));

  // R4: a read carries the lock and a write releases it.
  a_r4_lock_dir: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memWrite != memLock));

  // R4: an accepted locked read is always followed by a write before the result.
  a_r4_read_then_write: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RD_WAIT && memRspValid) |=> (memReqValid && memWrite));

endmodule

// File: rtl/atomic_cmpadd_unit.sv
module atomic_cmpadd_unit #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [3:0]        reqCond,
  input  logic              reqWide,
  input  logic [1:0]        reqMode,
  input  logic              reqLockPfx,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqCmp,
  input  logic [DATA_W-1:0] reqAddend,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memWrite,
  output logic              memLock,
  output logic              memWide,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspOld,
  output logic [5:0]        rspFlags,
  output logic              rspCondMet,
  output logic              rspIllegal
);
  import acx_pkg::*;

  acx_strobe_t strobe;
  logic        reqIllegal;

  acx_control u_control (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqIllegal  (reqIllegal),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .memWrite    (memWrite),
    .memLock     (memLock),
    .rspValid    (rspValid),
    .strobe      (strobe)
  );

  acx_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqCond    (reqCond),
    .reqWide    (reqWide),
    .reqMode    (reqMode),
    .reqLockPfx (reqLockPfx),
    .reqAddr    (reqAddr),
    .reqCmp     (reqCmp),
    .reqAddend  (reqAddend),
    .memRspData (memRspData),
    .reqIllegal (reqIllegal),
    .memWide    (memWide),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .rspOld     (rspOld),
    .rspFlags   (rspFlags),
    .rspCondMet (rspCondMet),
    .rspIllegal (rspIllegal)
  );

  // R10: the address stays put while a memory request waits.
  a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> $stable(memAddr));

endmodule

// File: tb/atomic_cmpadd_unit_bench.sv
`timescale 1ns/1ps
module atomic_cmpadd_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [3:0]  reqCond = '0;
  logic        reqWide = 1'b0;
  logic [1:0]  reqMode = '0;
  logic        reqLockPfx = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [63:0] reqCmp = '0, reqAddend = '0;
  logic        memReqValid, memWrite, memLock, memWide;
  logic        memReqReady = 1'b0;
  logic [31:0] memAddr;
  logic [63:0] memWdata;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        rspValid, rspCondMet, rspIllegal;
  logic [63:0] rspOld;
  logic [5:0]  rspFlags;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  atomic_cmpadd_unit u_atomic_cmpadd_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqCond(reqCond), .reqWide(reqWide), .reqMode(reqMode), .reqLockPfx(reqLockPfx),
    .reqAddr(reqAddr), .reqCmp(reqCmp), .reqAddend(reqAddend),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memWrite(memWrite),
    .memLock(memLock), .memWide(memWide), .memAddr(memAddr), .memWdata(memWdata),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .rspValid(rspValid), .rspOld(rspOld), .rspFlags(rspFlags),
    .rspCondMet(rspCondMet), .rspIllegal(rspIllegal)
  );

  // Behavioural memory with random acceptance and a one-cycle response.
  logic [63:0] memArr [16];
  int          memAccesses = 0;
  int          readsLocked = 0, writesUnlocked = 0, writesSeen = 0;

  always @(posedge clk) begin
    memRspValid <= 1'b0;
    if (memReqValid && memReqReady) begin
      memAccesses <= memAccesses + 1;
      memRspValid <= 1'b1;
      if (memWrite) begin
        writesSeen <= writesSeen + 1;
        if (!memLock) writesUnlocked <= writesUnlocked + 1;
        if (memWide) memArr[memAddr[3:0]] <= memWdata;
        else         memArr[memAddr[3:0]][31:0] <= memWdata[31:0];
      end else begin
        if (memLock) readsLocked <= readsLocked + 1;
        memRspData <= memArr[memAddr[3:0]];
      end
    end
    memReqReady <= ($urandom_range(0, 3) != 0);
  end

  function automatic logic [5:0] mdlFlags(logic [63:0] m, logic [63:0] c, logic w);
    logic [64:0] d;
    logic        cf, zf, sf, of, af, pf;
    if (w) begin
      d  = {1'b0, m} - {1'b0, c};
      cf = d[64];
      zf = (d[63:0] == 64'd0);
      sf = d[63];
      of = (m[63] != c[63]) && (d[63] != m[63]);
    end else begin
      d  = {33'd0, m[31:0]} - {33'd0, c[31:0]};
      cf = d[32];
      zf = (d[31:0] == 32'd0);
      sf = d[31];
      of = (m[31] != c[31]) && (d[31] != m[31]);
    end
    af = (m[3:0] < c[3:0]);
    pf = ($countones(d[7:0]) % 2) == 0;
    return {of, sf, zf, af, pf, cf};
  endfunction

  function automatic logic mdlCond(logic [3:0] s, logic [5:0] f);
    logic of, sf, zf, pf, cf;
    {of, sf, zf} = f[5:3];
    pf = f[1];
    cf = f[0];
    case (s)
      4'h0: return of;
      4'h1: return !of;
      4'h2: return cf;
      4'h3: return !cf;
      4'h4: return zf;
      4'h5: return !zf;
      4'h6: return cf || zf;
      4'h7: return !cf && !zf;
      4'h8: return sf;
      4'h9: return !sf;
      4'hA: return pf;
      4'hB: return !pf;
      4'hC: return sf != of;
      4'hD: return sf == of;
      4'hE: return zf || (sf != of);
      default: return !zf && (sf == of);
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic runOp(logic [3:0] c, logic w, logic [1:0] md, logic lp,
                       logic [3:0] a, logic [63:0] cmpv, logic [63:0] addv, string req);
    logic [63:0] m, expOld, expNew;
    logic [5:0]  expF;
    logic        expC, illegal, busyOk;
    int          accBefore, rdBefore, wrBefore, wrAllBefore;
    m       = memArr[a];
    illegal = (md == 2'd3) || lp;
    expF    = mdlFlags(m, cmpv, w);
    expC    = mdlCond(c, expF);
    expOld  = w ? m : {32'd0, m[31:0]};
    if (illegal || !expC) expNew = m;
    else if (w)           expNew = m + addv;
    else                  expNew = {m[63:32], m[31:0] + addv[31:0]};
    accBefore = memAccesses; rdBefore = readsLocked;
    wrBefore = writesUnlocked; wrAllBefore = writesSeen;

    @(negedge clk);
    reqValid = 1'b1; reqCond = c; reqWide = w; reqMode = md; reqLockPfx = lp;
    reqAddr = {28'd0, a}; reqCmp = cmpv; reqAddend = addv;
    @(negedge clk);
    reqValid = 1'b0;
    busyOk = 1'b1;
    while (!rspValid) begin
      if (reqReady) busyOk = 1'b0;
      @(negedge clk);
    end
    check(busyOk, "R10", "reqReady while busy", {63'd0, busyOk}, 64'd1);
    check(rspIllegal == illegal, illegal ? (md == 2'd3 ? "R7" : "R8") : req,
          "illegal", {63'd0, rspIllegal}, {63'd0, illegal});
    if (illegal) begin
      check(memAccesses == accBefore && rspOld == 0 && rspFlags == 0 && !rspCondMet,
            md == 2'd3 ? "R7" : "R8", "no access / zero result",
            64'(memAccesses - accBefore), 64'd0);
    end else begin
      check(rspOld == expOld, "R5", "old value", rspOld, expOld);
      check(rspFlags == expF, req, "flags (R2 R9)", {58'd0, rspFlags}, {58'd0, expF});
      check(rspCondMet == expC, req, "condition (R1 R3)", {63'd0, rspCondMet}, {63'd0, expC});
      check(readsLocked == rdBefore + 1 && writesUnlocked == wrBefore + 1 &&
            writesSeen == wrAllBefore + 1, "R4", "one locked read, one unlocking write",
            64'(writesUnlocked - wrBefore), 64'd1);
    end
    @(negedge clk);
    check(memArr[a] == expNew, illegal ? "R7" : "R4", "memory after op", memArr[a], expNew);
    check(reqReady == 1'b1, "R10", "ready after result", {63'd0, reqReady}, 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) memArr[i] = {$urandom, $urandom};
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R11: reset state
    check(reqReady && !rspValid && !memReqValid, "R11", "reset outputs",
          {61'd0, reqReady, rspValid, memReqValid}, 64'b100);

    // R1: every selector on a few fixed operand pairs
    for (int s = 0; s < 16; s++) begin
      memArr[1] = 64'h0000_0000_8000_0000;
      runOp(4'(s), 1'b0, 2'd0, 1'b0, 4'd1, 64'd1, 64'd5, "R1");
      memArr[2] = 64'd7;
      runOp(4'(s), 1'b1, 2'd1, 1'b0, 4'd2, 64'd7, 64'd3, "R1");
      memArr[3] = 64'd2;
      runOp(4'(s), 1'b1, 2'd2, 1'b0, 4'd3, 64'd9, 64'd1, "R1");
    end

    // R3: the add would overflow but the compare does not; OF condition must fail
    memArr[4] = 64'h0000_0000_7FFF_FFFF;
    runOp(4'h0, 1'b0, 2'd0, 1'b0, 4'd4, 64'd0, 64'd1, "R3");
    memArr[4] = 64'h7FFF_FFFF_FFFF_FFFF;
    runOp(4'h1, 1'b1, 2'd0, 1'b0, 4'd4, 64'd0, 64'd1, "R3");

    // R6: 32-bit with nonzero upper half in memory and operands
    memArr[5] = 64'hDEAD_BEEF_0000_0010;
    runOp(4'h4, 1'b0, 2'd0, 1'b0, 4'd5, 64'hFFFF_FFFF_0000_0010, 64'hAAAA_0000_FFFF_FFFF, "R6");
    memArr[6] = 64'h1234_5678_FFFF_FFFF;
    runOp(4'h5, 1'b0, 2'd1, 1'b0, 4'd6, 64'd0, 64'd2, "R6");

    // R9: parity and half borrow
    memArr[7] = 64'h0000_0000_0000_0010;
    runOp(4'hA, 1'b1, 2'd0, 1'b0, 4'd7, 64'h1, 64'h100, "R9");
    memArr[7] = 64'h0000_0000_0000_0003;
    runOp(4'hB, 1'b0, 2'd0, 1'b0, 4'd7, 64'h0, 64'h100, "R9");

    // R7 and R8: illegal forms
    runOp(4'h4, 1'b1, 2'd3, 1'b0, 4'd8, 64'd0, 64'd1, "R7");
    runOp(4'h5, 1'b0, 2'd0, 1'b1, 4'd8, 64'd0, 64'd1, "R8");
    runOp(4'h5, 1'b1, 2'd3, 1'b1, 4'd9, 64'd0, 64'd1, "R8");

    // Random mix (R2 R4 R5)
    for (int n = 0; n < 400; n++) begin
      logic [3:0]  ra;
      logic [63:0] rc;
      logic [1:0]  rm;
      ra = 4'($urandom_range(0, 15));
      case ($urandom_range(0, 3))
        0: rc = memArr[ra];
        1: rc = memArr[ra] + 64'($urandom_range(0, 2)) - 64'd1;
        default: rc = {$urandom, $urandom};
      endcase
      rm = ($urandom_range(0, 9) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
      runOp(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), rm,
            ($urandom_range(0, 14) == 0), ra, rc, {$urandom, $urandom}, "R2");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule